// File: doc/BRIEF.md
# ADC Sequencer with DMA Addressing

This block is the digital controller between a successive-approximation converter core and a DMA engine. A trigger starts a sequence: the block picks one or more analog inputs, starts the core once for each, and takes back each result word. Each result goes out as a DMA write with a buffer address. After a set number of whole sequences it raises an interrupt and a one-cycle DMA request.

The block has two resolutions. The 10-bit mode allows up to four sample/hold paths per sequence. The 12-bit mode always uses a single path. The resolution can only change while the block is disabled. The first input of a sequence comes from a fixed base field or from an automatic scan over a 13-bit input mask. Results are addressed in one of two ways. In conversion-order mode a running index is used. In scatter/gather mode each input has its own region, and the region size is a power of two.

Software writes a small register port. Address 0 is control, address 1 is the scan mask, address 2 is the base input, and address 3 is the interrupt acknowledge. The core is modelled as a start pulse with a channel number, followed later by a done pulse with a right-aligned result.

Top module: `adc_seq_dma`

## Requirements
- R1: Inputs 0 to 12 are selectable. Sample/hold slot k of a sequence converts input (first + k) mod 13. Outside scan mode, first is the base field, written at address 2 bits [3:0], and a value above 12 is stored as 12.
- R2: Control bit 1 selects 12-bit mode. A 12-bit sequence has exactly one conversion and passes the full 12-bit result. In 10-bit mode, result bits [11:10] are driven as zero.
- R3: A control write changes the resolution bit only when the enable bit (control bit 0) is already clear. Otherwise the old resolution stays.
- R4: In 10-bit mode, control bits [5:4] set the conversions per sequence: 0 gives 1, 1 gives 2, and 2 or 3 give 4. The conversions run in slot order, with one conv_start_o pulse each.
- R5: Control bits [9:6] hold N. After N+1 completed sequences irq_o is set and the sequence count restarts. irq_o stays high until a write to address 3 with bit 0 set. If a set and a clear happen in the same cycle, the set wins.
- R6: dma_req_o pulses for one cycle with every interrupt event, in the cycle that carries the sequence's last result.
- R7: With control bit 3 set, the DMA address is the number of results written since the last interrupt event (or since enable), taken modulo 16.
- R8: With control bit 3 clear, the DMA address is input × 2^B + (that input's result count mod 2^B). B is control bits [12:10], and the per-input counts clear while the block is disabled.
- R9: With control bit 2 set, each sequence's first input is the next set bit of the mask (address 1) above the previous one, wrapping to the lowest set bit. The scan restarts after a mask write or a disable. An empty mask gives input 0.
- R10: A trigger is ignored while disabled or while a sequence is running. Clearing enable aborts a sequence.
- R11: Each conv_done_i produces one dma_we_o pulse, one cycle later, carrying the address and data of that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | 13 | Register write data |
| trigger_i | input | 1 | Start-of-sequence trigger |
| conv_start_o | output | 1 | Start pulse to the converter core |
| conv_ch_o | output | 4 | Input to convert |
| conv_done_i | input | 1 | Conversion complete |
| conv_result_i | input | 12 | Conversion result, right-aligned |
| dma_we_o | output | 1 | DMA write strobe |
| dma_addr_o | output | 11 | DMA buffer word address |
| dma_data_o | output | 12 | DMA write data |
| dma_req_o | output | 1 | DMA request pulse on interrupt event |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench targets these corner cases:
- **Resolution write while enabled.** A 12-bit write made while the block is enabled must leave a four-slot sequence in place. A design that took the write would collapse the sequence to one conversion.
- **Slot wrap at input 12.** With a base of 12, the inputs must wrap to 0, 1 and 2. A design without the mod-13 step would ask the core for input 13.
- **Scan order.** The scan must wrap from the highest set mask bit back to the lowest. It must restart after a mask write, and an empty mask must give input 0. An off-by-one scanner would skip or repeat an input.
- **Per-input counters in scatter/gather.** Region size and the per-input counts are exercised, including the wrap of the counts. The interrupt count is checked against N+1; a design that counted N would raise the interrupt one sequence early. The conversion-order index must restart exactly after the last write of an interrupting sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH = 13;
  localparam int CH_W   = 4;
  localparam int RES_W  = 12;
  localparam int LO_W   = 10;
  localparam int CNT_W  = 4;
  localparam int BLOG_W = 3;
  localparam int WCNT_W = 7;
  localparam int ORD_W  = 4;
  localparam int CFG_W  = NUM_CH;
  localparam int AW     = CH_W + WCNT_W;
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} seq_st_e;

  typedef struct packed {
    logic              en;
    logic              res12;
    logic              scan;
    logic              ordered;
    logic [1:0]        nsh;
    logic [CNT_W-1:0]  smpi;
    logic [BLOG_W-1:0] blog;
    logic [NUM_CH-1:0] mask;
    logic [CH_W-1:0]   base;
  } seq_cfg_t;
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output seq_cfg_t         cfg_o,
  output logic             irq_clr_o,
  output logic             mask_wr_o
);
  seq_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        2'd0: begin
          cfg_q.en      <= wdata_i[0];
          if (!cfg_q.en) cfg_q.res12 <= wdata_i[1];
          cfg_q.scan    <= wdata_i[2];
          cfg_q.ordered <= wdata_i[3];
          cfg_q.nsh     <= wdata_i[5:4];
          cfg_q.smpi    <= wdata_i[9:6];
          cfg_q.blog    <= wdata_i[12:10];
        end
        2'd1: cfg_q.mask <= wdata_i;
        2'd2: cfg_q.base <= (wdata_i[CH_W-1:0] > CH_W'(NUM_CH-1)) ?
                            CH_W'(NUM_CH-1) : wdata_i[CH_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg_o     = cfg_q;
  assign irq_clr_o = we_i && (addr_i == 2'd3) && wdata_i[0];
  assign mask_wr_o = we_i && (addr_i == 2'd1);

  assert_res_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q.en) |-> $stable(cfg_q.res12));
  assert_base_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.base <= CH_W'(NUM_CH-1));
endmodule

// File: rtl/adc_seq_scan.sv
module adc_seq_scan
  import adc_seq_pkg::*;
(
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [CH_W-1:0]   prev_i,
  output logic [CH_W-1:0]   next_o
);
  logic found;

  // next set bit above prev, else lowest set bit, else 0
  always_comb begin
    next_o = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && mask_i[i] && (CH_W'(i) > prev_i)) begin
        next_o = CH_W'(i);
        found  = 1'b1;
      end
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && mask_i[i]) begin
        next_o = CH_W'(i);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_addr.sv
module adc_seq_addr
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic              wrap_i,
  input  logic              ordered_i,
  input  logic [BLOG_W-1:0] blog_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic [AW-1:0]     addr_o
);
  logic [ORD_W-1:0]  ord_q;
  logic [WCNT_W-1:0] wcnt_q [NUM_CH];
  logic [WCNT_W-1:0] wcnt_sel;
  logic [WCNT_W-1:0] wmask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ord_q <= '0;
    else if (clr_i)  ord_q <= '0;
    else if (wr_i)   ord_q <= wrap_i ? '0 : ord_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wcnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            wcnt_q[g] <= '0;
      else if (clr_i)                         wcnt_q[g] <= '0;
      else if (wr_i && ch_i == CH_W'(g))      wcnt_q[g] <= wcnt_q[g] + 1'b1;
    end
  end

  always_comb begin
    wcnt_sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_i == CH_W'(i)) wcnt_sel = wcnt_q[i];
  end

  assign wmask  = ~({WCNT_W{1'b1}} << blog_i);
  assign addr_o = ordered_i ? AW'(ord_q)
                            : ((AW'(ch_i) << blog_i) | AW'(wcnt_sel & wmask));

  assert_ord_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wrap_i && !clr_i) |=> (ord_q == '0));
endmodule

// File: rtl/adc_seq_dma.sv
module adc_seq_dma
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             trigger_i,
  output logic             conv_start_o,
  output logic [CH_W-1:0]  conv_ch_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  output logic             dma_we_o,
  output logic [AW-1:0]    dma_addr_o,
  output logic [RES_W-1:0] dma_data_o,
  output logic             dma_req_o,
  output logic             irq_o
);
  seq_cfg_t          cfg;
  logic              irq_clr, mask_wr;
  seq_st_e           state_q;
  logic [SLOT_W-1:0] slot_q, slot_last;
  logic [CH_W-1:0]   first_q, scan_ptr_q, scan_next, first_sel, cur_ch;
  logic [CH_W:0]     ch_sum;
  logic [CNT_W-1:0]  seq_cnt_q;
  logic              res_wr, seq_end, irq_evt;
  logic [AW-1:0]     addr_gen;

  adc_seq_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg), .irq_clr_o(irq_clr), .mask_wr_o(mask_wr)
  );

  adc_seq_scan u_scan (.mask_i(cfg.mask), .prev_i(scan_ptr_q), .next_o(scan_next));

  always_comb begin
    if (cfg.res12) slot_last = '0;
    else case (cfg.nsh)
      2'd0:    slot_last = 2'd0;
      2'd1:    slot_last = 2'd1;
      default: slot_last = 2'd3;
    endcase
  end

  assign first_sel = cfg.scan ? scan_next : cfg.base;
  assign ch_sum    = {1'b0, first_q} + {{(CH_W+1-SLOT_W){1'b0}}, slot_q};
  assign cur_ch    = (ch_sum >= (CH_W+1)'(NUM_CH)) ? CH_W'(ch_sum - (CH_W+1)'(NUM_CH))
                                                   : CH_W'(ch_sum);
  assign res_wr    = cfg.en && (state_q == ST_WAIT) && conv_done_i;
  assign seq_end   = res_wr && (slot_q == slot_last);
  assign irq_evt   = seq_end && (seq_cnt_q == cfg.smpi);

  assign conv_start_o = (state_q == ST_START);
  assign conv_ch_o    = cur_ch;

  adc_seq_addr u_addr (
    .clk_i, .rst_ni, .clr_i(!cfg.en), .wr_i(res_wr), .wrap_i(irq_evt),
    .ordered_i(cfg.ordered), .blog_i(cfg.blog), .ch_i(cur_ch), .addr_o(addr_gen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      slot_q     <= '0;
      first_q    <= '0;
      scan_ptr_q <= '1;
      seq_cnt_q  <= '0;
      dma_we_o   <= 1'b0;
      dma_addr_o <= '0;
      dma_data_o <= '0;
      dma_req_o  <= 1'b0;
    end else if (!cfg.en) begin
      state_q    <= ST_IDLE;
      scan_ptr_q <= '1;
      seq_cnt_q  <= '0;
      dma_we_o   <= 1'b0;
      dma_req_o  <= 1'b0;
    end else begin
      dma_we_o  <= 1'b0;
      dma_req_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (trigger_i) begin
          first_q <= first_sel;
          if (cfg.scan) scan_ptr_q <= scan_next;
          slot_q  <= '0;
          state_q <= ST_START;
        end
        ST_START: state_q <= ST_WAIT;
        default: if (conv_done_i) begin
          dma_we_o   <= 1'b1;
          dma_addr_o <= addr_gen;
          dma_data_o <= cfg.res12 ? conv_result_i
                                  : {{(RES_W-LO_W){1'b0}}, conv_result_i[LO_W-1:0]};
          if (slot_q == slot_last) begin
            state_q   <= ST_IDLE;
            seq_cnt_q <= irq_evt ? '0 : seq_cnt_q + 1'b1;
            dma_req_o <= irq_evt;
          end else begin
            slot_q  <= slot_q + 1'b1;
            state_q <= ST_START;
          end
        end
      endcase
      if (mask_wr) scan_ptr_q <= '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_o <= 1'b0;
    else if (irq_evt) irq_o <= 1'b1;
    else if (irq_clr) irq_o <= 1'b0;
  end

  assert_ch_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (conv_ch_o < CH_W'(NUM_CH)));
  assert_narrow_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_we_o && !cfg.res12) |-> (dma_data_o[RES_W-1:LO_W] == '0));
  assert_single_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && cfg.res12) |-> (slot_q == '0));
  assert_req_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (irq_o && dma_we_o));
  assert_irq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_o) && !$past(irq_clr)) |-> irq_o);
  assert_start_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> cfg.en);
  assert_write_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_wr |=> dma_we_o);
endmodule

// File: tb/adc_seq_dma_tb.sv
`timescale 1ns/1ps
module adc_seq_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [12:0] cfg_wdata = '0;
  logic        trigger = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [11:0] conv_result = '0;
  logic        dma_we;
  logic [10:0] dma_addr;
  logic [11:0] dma_data;
  logic        dma_req;
  logic        irq;

  always #2.5 clk = ~clk;

  adc_seq_dma u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .trigger_i(trigger), .conv_start_o(conv_start),
    .conv_ch_o(conv_ch), .conv_done_i(conv_done), .conv_result_i(conv_result),
    .dma_we_o(dma_we), .dma_addr_o(dma_addr), .dma_data_o(dma_data),
    .dma_req_o(dma_req), .irq_o(irq)
  );

  int nchk = 0, nerr = 0;
  // reference model state
  bit en_m, res12_m, scan_m, ord_m, irq_m;
  int nsh_m, smpi_m, blog_m, base_m, seq_m, ordc_m, sptr_m;
  bit [12:0] mask_m;
  int wc_m [13];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int next_scan(input bit [12:0] m, input int p);
    for (int i = p + 1; i < 13; i++) if (m[i]) return i;
    for (int i = 0; i < 13; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int nslots();
    if (res12_m) return 1;
    return (nsh_m == 0) ? 1 : (nsh_m == 1) ? 2 : 4;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 13'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ctrl(input bit en, input bit res, input bit sc, input bit od,
                          input int nsh, input int smpi, input int blog);
    wr(0, {19'b0, 3'(blog), 4'(smpi), 2'(nsh), od, sc, res, en});
    if (!en_m) res12_m = res;
    en_m = en; scan_m = sc; ord_m = od; nsh_m = nsh; smpi_m = smpi; blog_m = blog;
    if (!en) begin
      seq_m = 0; ordc_m = 0; sptr_m = -1;
      for (int i = 0; i < 13; i++) wc_m[i] = 0;
    end
  endtask

  task automatic set_mask(input bit [12:0] m);
    wr(1, int'(m)); mask_m = m; sptr_m = -1;
  endtask

  task automatic set_base(input int b);
    wr(2, b); base_m = (b > 12) ? 12 : b;
  endtask

  task automatic clr_irq();
    wr(3, 1); irq_m = 0;
    chk(irq == 1'b0, "R5 irq cleared by ack", int'(irq), 0);
  endtask

  task automatic run_seq();
    int first, n, ch, w, res, ea, ed;
    bit evt;
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    first = scan_m ? next_scan(mask_m, sptr_m) : base_m;
    if (scan_m) sptr_m = first;
    n = nslots();
    for (int k = 0; k < n; k++) begin
      w = 0;
      while (!conv_start && w < 20) begin @(negedge clk); w++; end
      chk(conv_start == 1'b1, "R4 start pulse per slot", int'(conv_start), 1);
      ch = (first + k) % 13;
      chk(int'(conv_ch) == ch, scan_m ? "R9 scan channel" : "R1 slot channel",
          int'(conv_ch), ch);
      repeat (1 + $urandom % 3) begin
        @(negedge clk);
        trigger = ($urandom % 2) == 1;   // busy trigger, R10
      end
      res = int'($urandom % 4096);
      conv_done = 1'b1; conv_result = 12'(res);
      @(negedge clk);
      conv_done = 1'b0; trigger = 1'b0;
      ea = ord_m ? ordc_m : ch * (1 << blog_m) + (wc_m[ch] % (1 << blog_m));
      ed = res12_m ? res : (res & 'h3FF);
      chk(dma_we == 1'b1, "R11 write strobe after done", int'(dma_we), 1);
      chk(int'(dma_addr) == ea, ord_m ? "R7 ordered address" : "R8 scatter address",
          int'(dma_addr), ea);
      chk(int'(dma_data) == ed, "R2 result data", int'(dma_data), ed);
      ordc_m = (ordc_m + 1) % 16;
      wc_m[ch] = (wc_m[ch] + 1) % 128;
      if (k == n - 1) begin
        evt = (seq_m == smpi_m);
        chk(dma_req == evt, "R6 dma request", int'(dma_req), int'(evt));
        if (evt) begin seq_m = 0; ordc_m = 0; irq_m = 1; end
        else seq_m++;
        chk(irq == irq_m, "R5 irq after N+1 sequences", int'(irq), int'(irq_m));
      end else begin
        chk(dma_req == 1'b0, "R6 no request mid-sequence", int'(dma_req), 0);
      end
    end
    @(negedge clk);
    chk(conv_start == 1'b0, "R10 idle after sequence", int'(conv_start), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    en_m = 0; res12_m = 0; irq_m = 0; sptr_m = -1; mask_m = '0; base_m = 0;
    for (int i = 0; i < 13; i++) wc_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 0 && dma_we == 0 && dma_req == 0 && conv_start == 0,
        "R5 reset state", int'({irq, dma_we, dma_req, conv_start}), 0);

    // R10: trigger while disabled
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(conv_start == 1'b0, "R10 trigger ignored when disabled", int'(conv_start), 0);
      @(negedge clk);
    end

    // R3: resolution locked while enabled
    set_ctrl(0, 0, 0, 1, 3, 1, 0);
    set_base(5);
    set_ctrl(1, 0, 0, 1, 3, 1, 0);
    set_ctrl(1, 1, 0, 1, 3, 1, 0);
    chk(res12_m == 0, "R3 model lock", int'(res12_m), 0);
    run_seq();   // must still be four slots
    run_seq();
    clr_irq();
    // R2: 12-bit mode after disable
    set_ctrl(0, 1, 0, 1, 3, 0, 0);
    set_ctrl(1, 1, 0, 1, 3, 0, 0);
    run_seq();
    clr_irq();

    // R1: base clamp and wrap at 12
    set_ctrl(0, 0, 0, 0, 2, 2, 2);
    set_base(15);
    set_ctrl(1, 0, 0, 0, 2, 2, 2);
    run_seq(); run_seq(); run_seq();
    clr_irq();

    // R9: scan wrap, restart, empty mask
    set_ctrl(0, 0, 1, 1, 0, 3, 0);
    set_mask(13'h1088);
    set_ctrl(1, 0, 1, 1, 0, 3, 0);
    run_seq(); run_seq(); run_seq(); run_seq();
    set_mask(13'h0081);
    run_seq(); run_seq();
    set_mask(13'h0000);
    run_seq();
    clr_irq();

    // R8: per-input count wrap at large region
    set_ctrl(0, 1, 0, 0, 0, 15, 7);
    set_base(9);
    set_ctrl(1, 1, 0, 0, 0, 15, 7);
    for (int i = 0; i < 130; i++) run_seq();
    clr_irq();

    // constrained random
    for (int it = 0; it < 40; it++) begin
      bit r, sc, od;
      int nsh, smpi, blog, nseq;
      r = $urandom % 2; sc = $urandom % 2; od = $urandom % 2;
      nsh = $urandom % 4; smpi = $urandom % 6; blog = $urandom % 8;
      set_ctrl(0, r, sc, od, nsh, smpi, blog);
      set_mask(13'($urandom));
      set_base($urandom % 16);
      set_ctrl(1, r, sc, od, nsh, smpi, blog);
      nseq = 1 + $urandom % 12;
      for (int s = 0; s < nseq; s++) begin
        run_seq();
        if (irq_m && ($urandom % 2) == 1) clr_irq();
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule